// File: doc/BRIEF.md
# Write-Protect Register Controller

This block owns the protection byte of a serial nonvolatile memory and decides, byte by byte, whether a write reaches the storage array. A serial front end hands it decoded events: the target address of each received data byte together with the byte and a strobe, plus stop and start conditions. The block samples an external protect pin. It returns a combinational acknowledge decision for the byte being received, so the front end can drive the ninth clock, and a permit flag for the current address. It also gives a strobe that launches a timed nonvolatile cycle, a busy flag for the length of that cycle, and the register byte for read-back.

The register sits at the topmost address. Two volatile latches form the write-enable chain: a general enable and a register enable. Three persistent bits are modelled as flops: two lock bits and a hardware-protect enable. These flops change only on the clock edge where a commit launches a timed cycle. The persistent bits can only be reached through a three-step arming sequence. When the protect pin is high and the protect-enable bit is set, the persistent bits are frozen, which gives a one-way read-only mode for the locked part of the array.

Top module: `wpr_ctrl`

## Requirements
- R1: After reset the volatile latches are 0 and the persistent bits hold `NV_INIT` (default 0). The read-back byte is {protect-enable, 0, 0, lock-hi, lock-lo, reg-enable, write-enable, 0}, with bit 7 first, so bits 6, 5 and 0 always read 0.
- R2: With reg-enable clear, a register byte 0x00 clears write-enable and 0x02 sets it. 0x06 sets reg-enable only if write-enable is already 1. Every other byte leaves the register unchanged. None of these starts a timed cycle.
- R3: With reg-enable set, a register byte whose bits 6, 5, 2 and 0 are 0 and whose bit 1 is 1 commits bit 7 to protect-enable, bit 4 to lock-hi and bit 3 to lock-lo. It also clears reg-enable, keeps write-enable and starts a timed cycle. Any other byte changes nothing.
- R4: While the protect pin is 1 and protect-enable is 1, a step-3 commit is dropped at the stop with no change and no cycle, and the permit flag at the register address is 0.
- R5: A start condition in place of the stop discards a pending register or array write: no change and no cycle.
- R6: Lock bits {hi,lo}: 00 locks nothing, 01 locks the top quarter, 10 the top half, 11 the whole array. For an array address, permit is write-enable AND NOT locked. For the register address, permit is reg-enable AND NOT hardware-protect. Permit is 0 while busy.
- R7: An array byte is acknowledged only when write-enable is 1 and no register byte was taken in the transaction. A register byte is acknowledged only as the first data byte of the transaction; later bytes are refused and ignored. Nothing is acknowledged while busy.
- R8: A stop after acknowledged array bytes starts a cycle only if at least one of them was permitted. A locked byte is acknowledged but starts no cycle. Every timed cycle clears reg-enable.
- R9: Busy is high for exactly `WC_CYCLES` cycles, starting the cycle after the committing stop. Bytes, stops and starts during busy are ignored.
- R10: The commit strobe is a one-cycle pulse in the cycle after the stop. The persistent bits change only in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| wp_i | input | 1 | External write-protect pin |
| addr_i | input | ADDR_W | Target address of the current data byte |
| data_i | input | 8 | Received data byte |
| byte_wr_i | input | 1 | Strobe: a write data byte is being received |
| stop_i | input | 1 | Stop condition seen |
| start_i | input | 1 | Start condition seen (aborts pending write) |
| ack_o | output | 1 | Acknowledge decision for the current byte |
| permit_o | output | 1 | Persistent write at addr_i would be allowed |
| nv_start_o | output | 1 | Pulse: timed nonvolatile cycle launched |
| busy_o | output | 1 | Timed cycle in progress |
| reg_rdata_o | output | 8 | Register read-back byte |

## Verification
Every one of the 256 register byte values is tried from four starting states: idle, write-enabled, armed with the pin low, and armed with protect-enable set and the pin high. This separates the volatile steps, the commit pattern, rejected patterns and the hardware freeze. For each lock setting the permit flag is swept over every array address, which pins down the block boundaries at the quarter and half points. Directed sequences cover a start replacing the stop, a second register byte, a locked but acknowledged write, and traffic during the busy window with the exact length of that window.

// File: rtl/wpr_pkg.sv
package wpr_pkg;
  typedef struct packed {
    logic wpen;
    logic bl1;
    logic bl0;
  } nv_bits_t;

  typedef struct packed {
    logic wel;
    logic rwel;
  } vol_bits_t;

  localparam int unsigned BYTE_W = 8;

  function automatic logic [BYTE_W-1:0] pack_reg(nv_bits_t nv, vol_bits_t vol);
    return {nv.wpen, 2'b00, nv.bl1, nv.bl0, vol.rwel, vol.wel, 1'b0};
  endfunction
endpackage

// File: rtl/wpr_lock_map.sv
module wpr_lock_map #(
  parameter int unsigned ADDR_W = 14
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        bl_i,
  output logic              locked_o
);
  localparam logic [1:0] TOP_QUARTER = 2'b11;

  logic in_half, in_quarter;
  assign in_half    = addr_i[ADDR_W-1];
  assign in_quarter = (addr_i[ADDR_W-1 -: 2] == TOP_QUARTER);

  always_comb begin
    unique case (bl_i)
      2'b00:   locked_o = 1'b0;
      2'b01:   locked_o = in_quarter;
      2'b10:   locked_o = in_half;
      default: locked_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/wpr_reg_eval.sv
module wpr_reg_eval
  import wpr_pkg::*;
(
  input  logic [BYTE_W-1:0] byte_i,
  input  vol_bits_t         vol_i,
  input  logic              hw_prot_i,
  output vol_bits_t         vol_o,
  output nv_bits_t          nv_o,
  output logic              commit_o
);
  logic unused_clear, nv_field_clear;
  assign unused_clear   = ~byte_i[0] & ~byte_i[5] & ~byte_i[6];
  assign nv_field_clear = ~byte_i[7] & ~byte_i[4] & ~byte_i[3];

  always_comb begin
    vol_o    = vol_i;
    nv_o     = nv_bits_t'({byte_i[7], byte_i[4], byte_i[3]});
    commit_o = 1'b0;
    if (unused_clear) begin
      if (!vol_i.rwel) begin
        if (nv_field_clear) begin
          unique case (byte_i[2:1])
            2'b00:   vol_o.wel  = 1'b0;
            2'b01:   vol_o.wel  = 1'b1;
            2'b11:   vol_o.rwel = vol_i.wel;  // arm only after enable
            default: ;
          endcase
        end
      end else if (!byte_i[2] && byte_i[1] && !hw_prot_i) begin
        vol_o.rwel = 1'b0;
        commit_o   = 1'b1;
      end
    end
  end
endmodule

// File: rtl/wpr_txn.sv
module wpr_txn
  import wpr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              busy_i,
  input  logic              addr_is_reg_i,
  input  logic              wel_i,
  input  logic              arr_permit_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic              byte_wr_i,
  input  logic              end_i,
  output logic              ack_o,
  output logic              reg_got_o,
  output logic [BYTE_W-1:0] reg_byte_o,
  output logic              arr_nv_o
);
  logic              reg_got_q, arr_seen_q, arr_nv_q;
  logic [BYTE_W-1:0] reg_byte_q;
  logic              take;

  always_comb begin
    if (busy_i)             ack_o = 1'b0;
    else if (addr_is_reg_i) ack_o = ~reg_got_q & ~arr_seen_q;
    else                    ack_o = wel_i & ~reg_got_q;
  end

  assign take = byte_wr_i & ack_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reg_got_q  <= 1'b0;
      arr_seen_q <= 1'b0;
      arr_nv_q   <= 1'b0;
      reg_byte_q <= '0;
    end else if (end_i) begin
      reg_got_q  <= 1'b0;
      arr_seen_q <= 1'b0;
      arr_nv_q   <= 1'b0;
    end else if (take) begin
      if (addr_is_reg_i) begin
        reg_got_q  <= 1'b1;
        reg_byte_q <= data_i;
      end else begin
        arr_seen_q <= 1'b1;
        arr_nv_q   <= arr_nv_q | arr_permit_i;
      end
    end
  end

  assign reg_got_o  = reg_got_q;
  assign reg_byte_o = reg_byte_q;
  assign arr_nv_o   = arr_nv_q;

  assert_reg_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_wr_i && addr_is_reg_i && reg_got_q) |=> $stable(reg_byte_q));
  assert_mixed_excl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_got_q && arr_seen_q));
endmodule

// File: rtl/wpr_cycle_timer.sv
module wpr_cycle_timer #(
  parameter int unsigned WC_CYCLES = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  localparam int unsigned CNT_W = $clog2(WC_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(WC_CYCLES);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (start_i)         cnt_q <= CNT_LOAD;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);

  assert_cnt_bound_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_LOAD);
  assert_start_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_o);
endmodule

// File: rtl/wpr_ctrl.sv
module wpr_ctrl
  import wpr_pkg::*;
#(
  parameter int unsigned ADDR_W    = 14,
  parameter int unsigned WC_CYCLES = 64,
  parameter logic [2:0]  NV_INIT   = 3'b000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wp_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        data_i,
  input  logic              byte_wr_i,
  input  logic              stop_i,
  input  logic              start_i,
  output logic              ack_o,
  output logic              permit_o,
  output logic              nv_start_o,
  output logic              busy_o,
  output logic [7:0]        reg_rdata_o
);
  localparam logic [ADDR_W-1:0] REG_ADDR = '1;

  vol_bits_t vol_q, vol_next;
  nv_bits_t  nv_q, nv_next;
  logic      nv_start_q;
  logic      busy, hw_prot, addr_is_reg, locked, arr_permit;
  logic      stop_eff, start_eff, reg_got, arr_nv, reg_commit, arr_go, reg_go, cycle_go;
  logic [BYTE_W-1:0] reg_byte;

  assign hw_prot     = wp_i & nv_q.wpen;
  assign addr_is_reg = (addr_i == REG_ADDR);
  assign stop_eff    = stop_i & ~busy;
  assign start_eff   = start_i & ~busy;

  wpr_lock_map #(.ADDR_W(ADDR_W)) u_lock (
    .addr_i   (addr_i),
    .bl_i     ({nv_q.bl1, nv_q.bl0}),
    .locked_o (locked)
  );

  assign arr_permit = vol_q.wel & ~locked & ~busy;

  always_comb begin
    if (busy)             permit_o = 1'b0;
    else if (addr_is_reg) permit_o = vol_q.rwel & ~hw_prot;
    else                  permit_o = arr_permit;
  end

  wpr_txn u_txn (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .busy_i        (busy),
    .addr_is_reg_i (addr_is_reg),
    .wel_i         (vol_q.wel),
    .arr_permit_i  (arr_permit),
    .data_i        (data_i),
    .byte_wr_i     (byte_wr_i),
    .end_i         (stop_eff | start_eff),
    .ack_o         (ack_o),
    .reg_got_o     (reg_got),
    .reg_byte_o    (reg_byte),
    .arr_nv_o      (arr_nv)
  );

  wpr_reg_eval u_eval (
    .byte_i    (reg_byte),
    .vol_i     (vol_q),
    .hw_prot_i (hw_prot),
    .vol_o     (vol_next),
    .nv_o      (nv_next),
    .commit_o  (reg_commit)
  );

  assign arr_go   = stop_eff & arr_nv;
  assign reg_go   = stop_eff & reg_got & reg_commit;
  assign cycle_go = arr_go | reg_go;

  wpr_cycle_timer #(.WC_CYCLES(WC_CYCLES)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (cycle_go),
    .busy_o  (busy)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vol_q      <= '0;
      nv_q       <= nv_bits_t'(NV_INIT);
      nv_start_q <= 1'b0;
    end else begin
      nv_start_q <= cycle_go;
      if (stop_eff && reg_got) begin
        vol_q <= vol_next;
        if (reg_commit) nv_q <= nv_next;
      end else if (arr_go) begin
        vol_q.rwel <= 1'b0;
      end
    end
  end

  assign nv_start_o  = nv_start_q;
  assign busy_o      = busy;
  assign reg_rdata_o = pack_reg(nv_q, vol_q);

  assert_nv_only_on_commit_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(nv_q) |-> nv_start_o);
  assert_pulse_single_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nv_start_o |=> !nv_start_o);
  assert_rwel_needs_wel_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vol_q.rwel |-> vol_q.wel);
  assert_cycle_clears_rwel_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nv_start_o |-> !vol_q.rwel);
  assert_busy_follows_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nv_start_o |-> busy_o);
  assert_busy_silent_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (!ack_o && !permit_o));
  assert_hw_freeze_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_prot |=> $stable(nv_q));
  assert_nack_no_wel_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!addr_is_reg && !vol_q.wel) |-> !ack_o);
endmodule

// File: tb/tb_wpr_ctrl.sv
`timescale 1ns/1ps
module tb_wpr_ctrl;
  localparam int          AW   = 14;
  localparam int          WC   = 8;
  localparam logic [13:0] REGA = 14'h3FFF;

  logic        clk = 1'b0;
  logic        rst_n, wp, byte_wr, stop, start;
  logic [13:0] addr;
  logic [7:0]  data;
  logic        ack, permit, nv_start, busy;
  logic [7:0]  rdata;

  int checks = 0;
  int errors = 0;

  logic       m_wel, m_rwel;
  logic [2:0] m_nv;

  always #2 clk = ~clk;

  wpr_ctrl #(.ADDR_W(AW), .WC_CYCLES(WC), .NV_INIT(3'b000)) dut (
    .clk_i(clk), .rst_ni(rst_n), .wp_i(wp), .addr_i(addr), .data_i(data),
    .byte_wr_i(byte_wr), .stop_i(stop), .start_i(start), .ack_o(ack),
    .permit_o(permit), .nv_start_o(nv_start), .busy_o(busy), .reg_rdata_o(rdata)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd();
    return {m_nv[2], 2'b00, m_nv[1:0], m_rwel, m_wel, 1'b0};
  endfunction

  function automatic logic m_locked(input int a, input logic [1:0] bl);
    case (bl)
      2'd0:    return 1'b0;
      2'd1:    return a >= 'h3000;
      2'd2:    return a >= 'h2000;
      default: return 1'b1;
    endcase
  endfunction

  task automatic m_reg(input logic [7:0] v, output logic commit);
    commit = 1'b0;
    if (v[0] | v[5] | v[6]) return;
    if (!m_rwel) begin
      if (v[7] | v[4] | v[3]) return;
      if (v == 8'h00)                m_wel  = 1'b0;
      else if (v == 8'h02)           m_wel  = 1'b1;
      else if (v == 8'h06 && m_wel)  m_rwel = 1'b1;
    end else if (!v[2] && v[1] && !(wp && m_nv[2])) begin
      m_nv   = {v[7], v[4], v[3]};
      m_rwel = 1'b0;
      commit = 1'b1;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wp = 1'b0; byte_wr = 1'b0; stop = 1'b0; start = 1'b0;
    addr = '0; data = '0;
    @(negedge clk);
    rst_n = 1'b1;
    m_wel = 1'b0; m_rwel = 1'b0; m_nv = 3'b000;
  endtask

  task automatic send_byte(input logic [13:0] a, input logic [7:0] d, output logic a_ack);
    @(negedge clk);
    addr = a; data = d; byte_wr = 1'b1;
    #1 a_ack = ack;
    @(negedge clk);
    byte_wr = 1'b0;
  endtask

  task automatic send_stop(output logic s, output int n);
    @(negedge clk);
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    s = nv_start;
    n = 0;
    while (busy) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic reg_op(input logic [7:0] v);
    logic a, c, s;
    int n;
    send_byte(REGA, v, a);
    m_reg(v, c);
    send_stop(s, n);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R9 actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic a, s, c;
    int n;
    do_reset();

    // R1 reset state
    #1;
    chk("R1 reset rdata", rdata, 8'h00);
    chk("R1 reset busy", busy, 1'b0);
    chk("R1 reset nv_start", nv_start, 1'b0);

    // R7 array byte without write-enable
    send_byte(14'h0100, 8'h5A, a);
    chk("R7 nack without wel", a, 1'b0);
    send_stop(s, n);
    chk("R8 no cycle after nack", s, 1'b0);

    // R2 set write-enable
    send_byte(REGA, 8'h02, a);
    chk("R7 first reg byte ack", a, 1'b1);
    send_stop(s, n);
    chk("R2 volatile no cycle", s, 1'b0);
    chk("R2 volatile no busy", n, 0);
    chk("R2 wel set", rdata, 8'h02);

    // R7 second register byte refused and ignored
    send_byte(REGA, 8'h02, a);
    send_byte(REGA, 8'h00, a);
    chk("R7 second reg byte nack", a, 1'b0);
    send_stop(s, n);
    chk("R7 second reg byte ignored", rdata, 8'h02);

    // R8 array write clears rwel, R9 busy length
    send_byte(REGA, 8'h06, a);
    send_stop(s, n);
    chk("R2 rwel armed", rdata, 8'h06);
    @(negedge clk); addr = 14'h0123; #1;
    chk("R6 permit unlocked", permit, 1'b1);
    send_byte(14'h0123, 8'h77, a);
    chk("R7 array ack", a, 1'b1);
    send_stop(s, n);
    chk("R8 array cycle", s, 1'b1);
    chk("R9 busy length", n, WC);
    chk("R8 rwel cleared", rdata, 8'h02);

    // R1 R2 R3 R4 register byte sweep from four states
    for (int mode = 0; mode < 4; mode++) begin
      for (int v = 0; v < 256; v++) begin
        do_reset();
        if (mode >= 1) reg_op(8'h02);
        if (mode >= 2) reg_op(8'h06);
        if (mode == 3) begin
          reg_op(8'h82);
          reg_op(8'h06);
          wp = 1'b1;
        end
        send_byte(REGA, v[7:0], a);
        chk("R7 reg first byte ack", a, 1'b1);
        m_reg(v[7:0], c);
        send_stop(s, n);
        if (mode < 2) begin
          chk("R2 sweep cycle", s, c);
          chk("R2 sweep rdata", rdata, exp_rd());
        end else if (mode == 2) begin
          chk("R3 sweep cycle", s, c);
          chk("R3 sweep busy", n, c ? WC : 0);
          chk("R3 sweep rdata", rdata, exp_rd());
        end else begin
          chk("R4 sweep cycle", s, 1'b0);
          chk("R4 sweep rdata", rdata, exp_rd());
        end
        chk("R1 unused bits zero", {rdata[6:5], rdata[0]}, 3'b000);
      end
    end

    // R6 lock map sweep over every array address
    for (int bl = 0; bl < 4; bl++) begin
      do_reset();
      reg_op(8'h02);
      reg_op(8'h06);
      reg_op({3'b000, bl[1:0], 3'b010});
      chk("R3 lock commit rdata", rdata, exp_rd());
      for (int ad = 0; ad < 'h3FFF; ad++) begin
        addr = ad[13:0];
        #1;
        chk("R6 permit sweep", permit, !m_locked(ad, bl[1:0]));
      end
      addr = REGA; #1;
      chk("R6 reg permit rwel clear", permit, 1'b0);
      if (bl == 3) begin
        send_byte(14'h0000, 8'hAA, a);
        chk("R8 locked byte acked", a, 1'b1);
        send_stop(s, n);
        chk("R8 locked no cycle", s, 1'b0);
        chk("R8 locked no busy", n, 0);
      end
      if (bl == 0) begin
        reg_op(8'h00);
        for (int ad = 0; ad < 'h3FFF; ad += 'h101) begin
          addr = ad[13:0];
          #1;
          chk("R6 permit without wel", permit, 1'b0);
        end
      end
    end

    // R5 start aborts a step-3 commit, sequence stays armed
    do_reset();
    reg_op(8'h02);
    reg_op(8'h06);
    send_byte(REGA, 8'h1A, a);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk("R5 abort no cycle", nv_start, 1'b0);
    chk("R5 abort unchanged", rdata, 8'h06);
    send_stop(s, n);
    chk("R5 later stop no cycle", s, 1'b0);
    send_byte(REGA, 8'h1A, a);
    send_stop(s, n);
    chk("R5 still armed commit", s, 1'b1);
    chk("R5 commit result", rdata, 8'h1A);

    // R5 start aborts a pending array write
    do_reset();
    reg_op(8'h02);
    send_byte(14'h0010, 8'h33, a);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk("R5 array abort", nv_start, 1'b0);
    send_stop(s, n);
    chk("R5 array abort stop", s, 1'b0);

    // R4 R6 register permit under hardware protect
    do_reset();
    reg_op(8'h02);
    reg_op(8'h06);
    addr = REGA; #1;
    chk("R6 reg permit armed", permit, 1'b1);
    reg_op(8'h82);
    reg_op(8'h06);
    wp = 1'b1; addr = REGA; #1;
    chk("R4 reg permit protected", permit, 1'b0);
    wp = 1'b0; #1;
    chk("R4 reg permit pin low", permit, 1'b1);

    // R9 R10 traffic during busy ignored, single pulse
    do_reset();
    reg_op(8'h02);
    reg_op(8'h06);
    send_byte(14'h0040, 8'h55, a);
    @(negedge clk); stop = 1'b1;
    @(negedge clk); stop = 1'b0;
    chk("R10 pulse after stop", nv_start, 1'b1);
    chk("R9 busy starts", busy, 1'b1);
    addr = REGA; data = 8'h00; byte_wr = 1'b1;
    #1;
    chk("R9 ack during busy", ack, 1'b0);
    chk("R9 permit during busy", permit, 1'b0);
    @(negedge clk); byte_wr = 1'b0; stop = 1'b1;
    #1;
    chk("R10 pulse one cycle", nv_start, 1'b0);
    @(negedge clk); stop = 1'b0;
    while (busy) @(negedge clk);
    chk("R9 busy traffic ignored", rdata, 8'h02);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule